// File: doc/BRIEF.md
# Machine-Mode CSR Unit with Sticky Event Interrupts

This block holds the machine-level control and status registers of a small 32-bit core. The pipeline reaches it through a single-cycle access port: a 12-bit register number, an operation code (read, write, bit-set, bit-clear) and write data. Read data and an illegal-access flag come back in the same cycle. Any state change the access causes is visible from the next cycle.

Alongside the fixed identification words, the unit keeps two free-running 64-bit counters, one for clock cycles and one for retired instructions. It also holds the interrupt enable and pending words. Two of the pending bits are sticky: one latches when any digital input pin changes, the other when a message arrives. Both stay set until software clears them. The pending bit for the machine timer follows the timer-compare level directly.

The unit drives a gated interrupt request and a clock-mode bit. It also decodes a relocatable 256-byte memory-mapped window for a 32-bit bus address, whose base is set through a register.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, the enable word (0x304), the custom pending bits, the clock-mode register (0x800), the window base (0x801), both counters' upper halves and the instruction counter all read zero.
- R2: Fixed words read as follows: 0x301 gives 0x40801107, 0xF11 gives 0, 0xF12 gives 53, 0xF13 gives 0x6F435652 ("R" in the low byte, then "V", "C", "o"), and 0xF14 gives 0. A write to 0x301 is legal and leaves its value unchanged.
- R3: acc_op encodes 0 = read, 1 = write, 2 = set the bits that are 1 in the data, 3 = clear the bits that are 1 in the data. acc_rdata shows the current value in the same cycle, and the new value is read from the next cycle.
- R4: The cycle counter adds one every clock. Its low half reads at 0xB00/0xC00/0xC01 and its high half at 0xB80/0xC80/0xC81. A write to either half at 0xB00 or 0xB80 replaces that half, and the counter does not advance in that cycle.
- R5: The instruction counter adds one in each cycle with retire high. Its low half reads at 0xB02/0xC02 and its high half at 0xB82/0xC82. A write replaces that half and suppresses the increment in that cycle.
- R6: Pending bit 16 of 0x344 latches on pin_evt and pending bit 17 on msg_evt. Each stays set until software writes 0 to it. If the event and a software clear of the same bit fall in one cycle, the bit stays set.
- R7: Bit 7 of 0x344 reads timer_lvl, and writes to it have no effect. In 0x304 only bits 7, 16 and 17 are writable. All other bits of 0x304 and 0x344 read zero.
- R8: irq_req is high exactly when some bit among 7, 16 and 17 is set in both 0x304 and 0x344.
- R9: Bit 0 of 0x800 is writable and drives clk_lowpower. Bits 31:1 read zero.
- R10: mmio_hit is high exactly when the base in 0x801 is nonzero and at most 0xFFFFFF00, and bus_addr lies in [base, base+255]. Other base values disable the window.
- R11: acc_illegal is high for any access to an unlisted register number, and for any write, set or clear to 0xC00–0xC82 or 0xF11–0xF14. An illegal access returns zero read data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| acc_addr | input | 12 | Register number |
| acc_wdata | input | 32 | Write data or bit mask |
| acc_rdata | output | 32 | Current value of the addressed register |
| acc_illegal | output | 1 | Access is not permitted |
| pin_evt | input | 1 | Some digital input pin changed state |
| msg_evt | input | 1 | A message was received |
| timer_lvl | input | 1 | Timer-compare level |
| retire | input | 1 | One instruction retired this cycle |
| irq_req | output | 1 | Enabled interrupt pending |
| clk_lowpower | output | 1 | Clock mode: 1 selects the fixed slow mode |
| bus_addr | input | 32 | Bus address to decode |
| mmio_hit | output | 1 | bus_addr falls in the mapped window |

## Verification
Two pairs of functions can fall in the same cycle: a hardware event setting a sticky pending bit and a software clear of that bit, and a counter increment and a software write to the same counter. The bench drives pin_evt or msg_evt in the same cycle as a clear-op on 0x344 and expects the bit to read set afterwards. It also writes a counter half and expects the read in the next cycle to show exactly the written value, with the increment resuming only after that. Carry from the low half into the high half is provoked by writing all ones to the low half and reading both halves over the following cycles.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    localparam int XLEN = 32;
    localparam int CNT_W = 64;
    localparam int WIN_BYTES = 256;

    // interrupt bit positions
    localparam int TMR_BIT = 7;
    localparam int PIN_BIT = 16;
    localparam int MSG_BIT = 17;

    // register numbers
    localparam logic [11:0] A_ISA      = 12'h301;
    localparam logic [11:0] A_IEN      = 12'h304;
    localparam logic [11:0] A_IPEND    = 12'h344;
    localparam logic [11:0] A_CLKMODE  = 12'h800;
    localparam logic [11:0] A_WINBASE  = 12'h801;
    localparam logic [11:0] A_CYC_LO   = 12'hB00;
    localparam logic [11:0] A_RET_LO   = 12'hB02;
    localparam logic [11:0] A_CYC_HI   = 12'hB80;
    localparam logic [11:0] A_RET_HI   = 12'hB82;
    localparam logic [11:0] A_UCYC_LO  = 12'hC00;
    localparam logic [11:0] A_UTIM_LO  = 12'hC01;
    localparam logic [11:0] A_URET_LO  = 12'hC02;
    localparam logic [11:0] A_UCYC_HI  = 12'hC80;
    localparam logic [11:0] A_UTIM_HI  = 12'hC81;
    localparam logic [11:0] A_URET_HI  = 12'hC82;
    localparam logic [11:0] A_VENDOR   = 12'hF11;
    localparam logic [11:0] A_ARCH     = 12'hF12;
    localparam logic [11:0] A_IMPL     = 12'hF13;
    localparam logic [11:0] A_HART     = 12'hF14;

    // fixed identification words
    localparam logic [31:0] ISA_WORD    = 32'h4080_1107;
    localparam logic [31:0] VENDOR_WORD = 32'd0;
    localparam logic [31:0] ARCH_WORD   = 32'd53;
    localparam logic [31:0] IMPL_WORD   = {8'h6F, 8'h43, 8'h56, 8'h52};
    localparam logic [31:0] HART_WORD   = 32'd0;

    typedef struct packed {
        logic en_tmr;
        logic en_pin;
        logic en_msg;
        logic pd_pin;
        logic pd_msg;
    } irq_state_t;

    typedef struct packed {
        logic        lowpower;
        logic [31:0] base;
    } cfg_state_t;

    function automatic logic [31:0] apply_op(csr_op_e op, logic [31:0] cur,
                                             logic [31:0] wd);
        logic [31:0] res;
        case (op)
            OP_WRITE: res = wd;
            OP_SET:   res = cur | wd;
            OP_CLEAR: res = cur & ~wd;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
    parameter int WIDTH = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [WIDTH/2-1:0] wval,
    output logic [WIDTH-1:0]   count
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d[HALF-1:0] = wval;
        end else if (wr_hi) begin
            cnt_d[WIDTH-1:HALF] = wval;
        end else if (inc) begin
            cnt_d = cnt_q + {{(WIDTH-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/mcsr_irq.sv
module mcsr_irq
    import mcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ien_wr,
    input  logic        ipend_wr,
    input  logic [31:0] wval,
    input  logic        pin_evt,
    input  logic        msg_evt,
    input  logic        timer_lvl,
    output logic [31:0] ien_rd,
    output logic [31:0] ipend_rd,
    output logic        irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ien_wr) begin
            st_d.en_tmr = wval[TMR_BIT];
            st_d.en_pin = wval[PIN_BIT];
            st_d.en_msg = wval[MSG_BIT];
        end
        if (ipend_wr) begin
            st_d.pd_pin = wval[PIN_BIT];
            st_d.pd_msg = wval[MSG_BIT];
        end
        // hardware events take priority over a software clear
        if (pin_evt) st_d.pd_pin = 1'b1;
        if (msg_evt) st_d.pd_msg = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ien_rd           = '0;
        ien_rd[TMR_BIT]  = st_q.en_tmr;
        ien_rd[PIN_BIT]  = st_q.en_pin;
        ien_rd[MSG_BIT]  = st_q.en_msg;
        ipend_rd          = '0;
        ipend_rd[TMR_BIT] = timer_lvl;
        ipend_rd[PIN_BIT] = st_q.pd_pin;
        ipend_rd[MSG_BIT] = st_q.pd_msg;
    end

    assign irq = |(ien_rd & ipend_rd);
endmodule

// File: rtl/mcsr_window.sv
module mcsr_window #(
    parameter int AW  = 32,
    parameter int WIN = 256
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW-1:0] WIN_V = AW'(WIN);
    localparam logic [AW-1:0] LIMIT = {AW{1'b1}} - WIN_V + {{(AW-1){1'b0}}, 1'b1};

    logic          base_ok;
    logic [AW-1:0] offset;

    always_comb begin
        base_ok = (base != '0) && (base <= LIMIT);
        offset  = addr - base;
        hit     = base_ok && (addr >= base) && (offset < WIN_V);
    end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic [1:0]  acc_op,
    input  logic [11:0] acc_addr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_illegal,
    input  logic        pin_evt,
    input  logic        msg_evt,
    input  logic        timer_lvl,
    input  logic        retire,
    output logic        irq_req,
    output logic        clk_lowpower,
    input  logic [31:0] bus_addr,
    output logic        mmio_hit
);
    localparam int NCNT = 2;
    localparam int HALF = CNT_W / 2;

    csr_op_e     op;
    logic        known, ro, wr_req, wr_ok;
    logic [31:0] cur_val, new_val;
    logic        wr_ien, wr_ipend;
    logic [31:0] ien_rd, ipend_rd;

    logic [NCNT-1:0]  cnt_inc, cnt_wr_lo, cnt_wr_hi;
    logic [CNT_W-1:0] cnt_val [NCNT];

    cfg_state_t st_d, st_q;

    assign op = csr_op_e'(acc_op);

    // address decode and read selection
    always_comb begin
        known   = 1'b1;
        ro      = 1'b0;
        cur_val = '0;
        case (acc_addr)
            A_ISA:     cur_val = ISA_WORD;
            A_IEN:     cur_val = ien_rd;
            A_IPEND:   cur_val = ipend_rd;
            A_CLKMODE: cur_val = {31'd0, st_q.lowpower};
            A_WINBASE: cur_val = st_q.base;
            A_CYC_LO:  cur_val = cnt_val[0][HALF-1:0];
            A_CYC_HI:  cur_val = cnt_val[0][CNT_W-1:HALF];
            A_RET_LO:  cur_val = cnt_val[1][HALF-1:0];
            A_RET_HI:  cur_val = cnt_val[1][CNT_W-1:HALF];
            A_UCYC_LO, A_UTIM_LO: begin
                cur_val = cnt_val[0][HALF-1:0];
                ro      = 1'b1;
            end
            A_UCYC_HI, A_UTIM_HI: begin
                cur_val = cnt_val[0][CNT_W-1:HALF];
                ro      = 1'b1;
            end
            A_URET_LO: begin
                cur_val = cnt_val[1][HALF-1:0];
                ro      = 1'b1;
            end
            A_URET_HI: begin
                cur_val = cnt_val[1][CNT_W-1:HALF];
                ro      = 1'b1;
            end
            A_VENDOR: begin cur_val = VENDOR_WORD; ro = 1'b1; end
            A_ARCH:   begin cur_val = ARCH_WORD;   ro = 1'b1; end
            A_IMPL:   begin cur_val = IMPL_WORD;   ro = 1'b1; end
            A_HART:   begin cur_val = HART_WORD;   ro = 1'b1; end
            default:  known = 1'b0;
        endcase
    end

    always_comb begin
        wr_req      = acc_en && (op != OP_READ);
        acc_illegal = acc_en && (!known || (wr_req && ro));
        wr_ok       = wr_req && known && !ro;
        new_val     = apply_op(op, cur_val, acc_wdata);
        acc_rdata   = acc_illegal ? 32'd0 : cur_val;
        wr_ien      = wr_ok && (acc_addr == A_IEN);
        wr_ipend    = wr_ok && (acc_addr == A_IPEND);
        cnt_inc      = {retire, 1'b1};
        cnt_wr_lo[0] = wr_ok && (acc_addr == A_CYC_LO);
        cnt_wr_hi[0] = wr_ok && (acc_addr == A_CYC_HI);
        cnt_wr_lo[1] = wr_ok && (acc_addr == A_RET_LO);
        cnt_wr_hi[1] = wr_ok && (acc_addr == A_RET_HI);
    end

    // configuration registers
    always_comb begin
        st_d = st_q;
        if (wr_ok && (acc_addr == A_CLKMODE)) st_d.lowpower = new_val[0];
        if (wr_ok && (acc_addr == A_WINBASE)) st_d.base     = new_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_lowpower = st_q.lowpower;

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            mcsr_counter #(.WIDTH(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (cnt_inc[g]),
                .wr_lo (cnt_wr_lo[g]),
                .wr_hi (cnt_wr_hi[g]),
                .wval  (new_val),
                .count (cnt_val[g])
            );
        end
    endgenerate

    mcsr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_wr    (wr_ien),
        .ipend_wr  (wr_ipend),
        .wval      (new_val),
        .pin_evt   (pin_evt),
        .msg_evt   (msg_evt),
        .timer_lvl (timer_lvl),
        .ien_rd    (ien_rd),
        .ipend_rd  (ipend_rd),
        .irq       (irq_req)
    );

    mcsr_window #(.AW(XLEN), .WIN(WIN_BYTES)) u_win (
        .base (st_q.base),
        .addr (bus_addr),
        .hit  (mmio_hit)
    );
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pin_evt,
    input logic        msg_evt,
    input logic        timer_lvl,
    input logic        irq_req,
    input logic        mmio_hit,
    input logic        acc_illegal,
    input logic [31:0] bus_addr,
    input logic [63:0] cyc_val,
    input logic        cyc_wr,
    input logic [31:0] ipend_val,
    input logic        ipend_wr,
    input logic [31:0] base_val
);
    // R6
    pin_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt |=> ipend_val[16]);

    // R6
    msg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_evt |=> ipend_val[17]);

    // R6
    pin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend_val[16] && !ipend_wr) |=> ipend_val[16]);

    // R4
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_wr |=> (cyc_val == $past(cyc_val) + 64'd1));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_lvl && ipend_val[17:16] == 2'b00) |-> !irq_req);

    // R10
    window_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_hit |-> (base_val != 32'd0 && bus_addr >= base_val));

    // R11
    illegal_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_illegal |=> $stable(base_val));
endmodule

bind mcsr_unit mcsr_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_evt     (pin_evt),
    .msg_evt     (msg_evt),
    .timer_lvl   (timer_lvl),
    .irq_req     (irq_req),
    .mmio_hit    (mmio_hit),
    .acc_illegal (acc_illegal),
    .bus_addr    (bus_addr),
    .cyc_val     (cnt_val[0]),
    .cyc_wr      (cnt_wr_lo[0] | cnt_wr_hi[0]),
    .ipend_val   (ipend_rd),
    .ipend_wr    (wr_ipend),
    .base_val    (st_q.base)
);

// File: tb/mcsr_unit_test.sv
module mcsr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_en;
    logic [1:0]  acc_op;
    logic [11:0] acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic        acc_illegal;
    logic        pin_evt, msg_evt, timer_lvl, retire;
    logic        irq_req, clk_lowpower;
    logic [31:0] bus_addr;
    logic        mmio_hit;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] rd;
    logic        ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcsr_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_op(acc_op),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_illegal(acc_illegal), .pin_evt(pin_evt), .msg_evt(msg_evt),
        .timer_lvl(timer_lvl), .retire(retire), .irq_req(irq_req),
        .clk_lowpower(clk_lowpower), .bus_addr(bus_addr), .mmio_hit(mmio_hit)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, sample combinational results
    task automatic step(logic en, logic [1:0] op, logic [11:0] a,
                        logic [31:0] wd, logic pe, logic me, logic rt);
        @(negedge clk);
        acc_en = en; acc_op = op; acc_addr = a; acc_wdata = wd;
        pin_evt = pe; msg_evt = me; retire = rt;
        #1;
        rd = acc_rdata;
        ill = acc_illegal;
    endtask

    task automatic rdreg(logic [11:0] a);
        step(1'b1, 2'd0, a, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wrreg(logic [1:0] op, logic [11:0] a, logic [31:0] wd);
        step(1'b1, op, a, wd, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic listed(int a);
        case (a)
            'h301, 'h304, 'h344, 'h800, 'h801, 'hB00, 'hB02, 'hB80, 'hB82,
            'hC00, 'hC01, 'hC02, 'hC80, 'hC81, 'hC82,
            'hF11, 'hF12, 'hF13, 'hF14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] c0;
        rst_n = 1'b0; acc_en = 0; acc_op = 0; acc_addr = 0; acc_wdata = 0;
        pin_evt = 0; msg_evt = 0; timer_lvl = 0; retire = 0; bus_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdreg(12'h304); chk("R1 ien", rd, 0);
        rdreg(12'h344); chk("R1 ipend", rd, 0);
        rdreg(12'h800); chk("R1 clkmode", rd, 0);
        chk("R1 lowpower pin", clk_lowpower, 0);
        rdreg(12'h801); chk("R1 base", rd, 0);
        rdreg(12'hB80); chk("R1 cycle hi", rd, 0);
        rdreg(12'hB02); chk("R1 instret lo", rd, 0);
        rdreg(12'hB82); chk("R1 instret hi", rd, 0);
        chk("R1 irq", irq_req, 0);

        // R2 identification words
        rdreg(12'h301); chk("R2 isa", rd, 32'h4080_1107);
        rdreg(12'hF11); chk("R2 vendor", rd, 0);
        rdreg(12'hF12); chk("R2 arch", rd, 53);
        rdreg(12'hF13); chk("R2 impl", rd, 32'h6F43_5652);
        rdreg(12'hF14); chk("R2 hart", rd, 0);
        wrreg(2'd1, 12'h301, 32'h0);
        chk("R2 isa write legal", ill, 0);
        rdreg(12'h301); chk("R2 isa unchanged", rd, 32'h4080_1107);

        // R3 operation codes on the base register
        wrreg(2'd1, 12'h801, 32'h0000_1234);
        chk("R3 old value same cycle", rd, 0);
        rdreg(12'h801); chk("R3 write", rd, 32'h0000_1234);
        wrreg(2'd2, 12'h801, 32'h0001_0001);
        rdreg(12'h801); chk("R3 set", rd, 32'h0001_1235);
        wrreg(2'd3, 12'h801, 32'h0000_0234);
        rdreg(12'h801); chk("R3 clear", rd, 32'h0001_1001);

        // R4 cycle counter
        rdreg(12'hB00); c0 = rd;
        rdreg(12'hB00); chk("R4 step", rd, c0 + 1);
        rdreg(12'hC00); chk("R4 user view", rd, c0 + 2);
        rdreg(12'hC01); chk("R4 time view", rd, c0 + 3);
        wrreg(2'd1, 12'hB80, 32'd5);
        wrreg(2'd1, 12'hB00, 32'hFFFF_FFFF);
        rdreg(12'hB00); chk("R4 write wins over step", rd, 32'hFFFF_FFFF);
        rdreg(12'hC80); chk("R4 carry into high", rd, 32'd6);
        rdreg(12'hC81); chk("R4 time high", rd, 32'd6);
        rdreg(12'hB00); chk("R4 low after wrap", rd, 32'd2);

        // R5 instruction counter
        wrreg(2'd1, 12'hB02, 32'd10);
        rdreg(12'hB02); chk("R5 write", rd, 10);
        repeat (3) step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        rdreg(12'hC02); chk("R5 retire count", rd, 13);
        step(1'b1, 2'd1, 12'hB02, 32'd100, 1'b0, 1'b0, 1'b1);
        rdreg(12'hB02); chk("R5 write beats retire", rd, 100);
        wrreg(2'd1, 12'hB82, 32'h77);
        rdreg(12'hC82); chk("R5 high half", rd, 32'h77);

        // R6 sticky pending bits
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b1, 1'b0, 1'b0);
        rdreg(12'h344); chk("R6 pin latch", rd, 32'h0001_0000);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b1, 1'b0);
        rdreg(12'h344); chk("R6 sticky both", rd, 32'h0003_0000);
        wrreg(2'd3, 12'h344, 32'h0001_0000);
        rdreg(12'h344); chk("R6 clear pin", rd, 32'h0002_0000);
        step(1'b1, 2'd3, 12'h344, 32'h0002_0000, 1'b0, 1'b1, 1'b0);
        rdreg(12'h344); chk("R6 event beats clear", rd, 32'h0002_0000);
        step(1'b1, 2'd1, 12'h344, 32'h0, 1'b1, 1'b0, 1'b0);
        rdreg(12'h344); chk("R6 pin event beats write0", rd, 32'h0001_0000);
        wrreg(2'd1, 12'h344, 32'h0);
        rdreg(12'h344); chk("R6 cleared", rd, 0);

        // R7 timer mirror and reserved bits
        timer_lvl = 1'b1; #1;
        rdreg(12'h344); chk("R7 timer mirror", rd, 32'h0000_0080);
        wrreg(2'd3, 12'h344, 32'hFFFF_FFFF);
        rdreg(12'h344); chk("R7 timer ignores write", rd, 32'h0000_0080);
        timer_lvl = 1'b0;
        wrreg(2'd1, 12'h344, 32'hFFFF_FFFF);
        rdreg(12'h344); chk("R7 ipend reserved", rd, 32'h0003_0000);
        wrreg(2'd1, 12'h304, 32'hFFFF_FFFF);
        rdreg(12'h304); chk("R7 ien reserved", rd, 32'h0003_0080);

        // R8 exhaustive enable x pending
        for (int pm = 0; pm < 8; pm++) begin
            for (int en = 0; en < 8; en++) begin
                logic [31:0] ew, pw;
                ew = 0; pw = 0;
                ew[7] = en[0]; ew[16] = en[1]; ew[17] = en[2];
                pw[16] = pm[1]; pw[17] = pm[2];
                wrreg(2'd1, 12'h304, ew);
                wrreg(2'd1, 12'h344, pw);
                timer_lvl = pm[0];
                step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
                chk("R8 irq gating", irq_req, |(pm[2:0] & en[2:0]));
            end
        end
        timer_lvl = 1'b0;

        // R9 clock mode
        wrreg(2'd1, 12'h800, 32'hFFFF_FFFF);
        rdreg(12'h800); chk("R9 only bit0", rd, 1);
        chk("R9 lowpower on", clk_lowpower, 1);
        wrreg(2'd3, 12'h800, 32'h1);
        rdreg(12'h800); chk("R9 lowpower off", clk_lowpower, 0);

        // R10 window sweep around a mid base
        wrreg(2'd1, 12'h801, 32'h0000_1000);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        for (int off = -2; off < 258; off++) begin
            @(negedge clk);
            bus_addr = 32'h0000_1000 + off;
            #1;
            chk("R10 mid window", mmio_hit, (off >= 0 && off < 256));
        end
        wrreg(2'd1, 12'h801, 32'hFFFF_FF00);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        bus_addr = 32'hFFFF_FFFF; #1; chk("R10 top window end", mmio_hit, 1);
        bus_addr = 32'hFFFF_FEFF; #1; chk("R10 below top", mmio_hit, 0);
        wrreg(2'd1, 12'h801, 32'hFFFF_FF01);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        bus_addr = 32'hFFFF_FFFF; #1; chk("R10 base too high", mmio_hit, 0);
        wrreg(2'd1, 12'h801, 32'h0);
        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        bus_addr = 32'h0000_0000; #1; chk("R10 zero disables", mmio_hit, 0);
        bus_addr = 32'h0000_0010; #1; chk("R10 zero disables b", mmio_hit, 0);

        // R11 full address sweep and read-only writes
        for (int a = 0; a < 4096; a++) begin
            rdreg(12'(a));
            if (!listed(a)) begin
                chk("R11 unlisted flag", ill, 1);
                chk("R11 unlisted data", rd, 0);
            end else begin
                chk("R11 listed flag", ill, 0);
            end
        end
        wrreg(2'd1, 12'hF12, 32'h0);
        chk("R11 ro write flag", ill, 1);
        rdreg(12'hF12); chk("R11 ro unchanged", rd, 53);
        wrreg(2'd2, 12'hC80, 32'h0);
        chk("R11 ro set flag", ill, 1);
        wrreg(2'd1, 12'h801, 32'h0000_4000);
        wrreg(2'd1, 12'h123, 32'h0000_8000);
        chk("R11 unlisted write flag", ill, 1);
        rdreg(12'h801); chk("R11 no state change", rd, 32'h0000_4000);

        step(1'b0, 2'd0, 12'h0, 32'd0, 1'b0, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule